// File: doc/BRIEF.md
# Level Interrupt Distributor with Acknowledge Handshake

This block collects level-sensitive interrupt requests from a parameterised number of sources, up to 255. It forwards the winning request to the interrupt line of one processor. Software programs it over a simple word-addressed register bus that has two register groups. The distributor group holds a global forwarding enable, per-source enable bits packed 32 to a word, and one routing byte per source. The processor-interface group holds a second forwarding enable, a priority mask, an acknowledge register and an end-of-interrupt register.

The processor services an interrupt in three steps. It reads the acknowledge register, which returns the ID of the lowest-numbered eligible source and marks that source in service. It then handles the event. It then writes the same ID to the end-of-interrupt register, which releases the block for the next request. The sources have no programmable priority, and only one source can be in service at a time.

Top module: `irq_distributor`

## Requirements
- R1: After reset `cpu_irq` is low even when every request is high, every enable word and every routing word reads 0, and an acknowledge read returns 1023.
- R2: Writing a word to byte offset 0x100+(N/32)*4 sets the enable of source N when bit N mod 32 of the data is 1. A 0 in that bit leaves the enable unchanged. Reading the same word returns the enable bits in the same positions.
- R3: The routing byte of source N sits at byte offset 0x800+N, in byte lane N mod 4 of its word. Only lanes whose byte enable is set are written. A source is forwarded only when bit 0 of its routing byte is 1.
- R4: `cpu_irq` can be high only when bit 0 of the distributor control word (offset 0x000) and bit 0 of the interface control word (offset 0x1000) are both 1.
- R5: The priority mask is the 16-bit field at offset 0x1004. A mask of 0 blocks forwarding. Any non-zero mask, for example 0xFFFF, lets forwarding through.
- R6: `cpu_irq` is high while at least one enabled, routed source has its request high and no source is in service. An acknowledge read (offset 0x100C) at that time returns the lowest such ID in bits [9:0].
- R7: An acknowledge read while `cpu_irq` is low returns the spurious ID 1023 and changes no state.
- R8: An acknowledged source stays in service, and `cpu_irq` stays low, until its end-of-interrupt write. This holds even if its request stays high. Further acknowledge reads in that time return 1023.
- R9: Writing the in-service ID to bits [9:0] at offset 0x1010 retires the source. A write carrying any other ID is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NSRC | Level request per source |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Word address (byte address bits 12:2) |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| cpu_irq | output | 1 | Interrupt line to processor 0 |

## Verification
A wrong in-service flag shows up at the ports at once. Either `cpu_irq` comes back in the cycle after an acknowledge, or it stays low after a matching end-of-interrupt. The acknowledge value also changes from an ID to 1023, or the other way round. A corrupted enable bit or routing byte shows up in the readback of its word in the same cycle. It also shows up as an ID missing from the acknowledge sequence that the request patterns produce. A broken lowest-ID search returns the wrong acknowledge ID on the first pattern that has more than one request high.

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int NSRC = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_irq,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [12:2]     bus_addr,
  input  logic [3:0]      bus_be,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            cpu_irq
);
  localparam int IDW = 10;
  localparam logic [IDW-1:0] SPURIOUS = 10'd1023;

  logic wr_go, rd_go;
  logic dctl_hit, sen_hit, tgt_hit, cctl_hit, pmask_hit, ack_hit, eoi_hit;
  logic dist_en, cpu_en;
  logic [15:0] pmask;
  logic act_v;
  logic [IDW-1:0] act_id, cand_id;
  logic cand_ok, present;
  logic [NSRC-1:0] en, pend;
  logic [7:0] tgt [NSRC];

  assign wr_go     = bus_sel & bus_wr;
  assign rd_go     = bus_sel & ~bus_wr;
  assign dctl_hit  = ~bus_addr[12] && bus_addr[11:2] == 10'd0;
  assign sen_hit   = ~bus_addr[12] && bus_addr[11:8] == 4'h1 && bus_addr[7] == 1'b0;
  assign tgt_hit   = ~bus_addr[12] && bus_addr[11];
  assign cctl_hit  = bus_addr[12] && bus_addr[11:2] == 10'd0;
  assign pmask_hit = bus_addr[12] && bus_addr[11:2] == 10'd1;
  assign ack_hit   = bus_addr[12] && bus_addr[11:2] == 10'd3;
  assign eoi_hit   = bus_addr[12] && bus_addr[11:2] == 10'd4;

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[n]  <= 1'b0;
        tgt[n] <= 8'h00;
      end else if (wr_go) begin
        if (sen_hit && bus_addr[6:2] == 5'(n / 32) && bus_wdata[n % 32])
          en[n] <= 1'b1;
        if (tgt_hit && bus_addr[10:2] == 9'(n / 4) && bus_be[n % 4])
          tgt[n] <= bus_wdata[8*(n % 4) +: 8];
      end
    end
    assign pend[n] = src_irq[n] & en[n] & tgt[n][0];
  end

  always_comb begin
    cand_ok = 1'b0;
    cand_id = SPURIOUS;
    for (int n = NSRC - 1; n >= 0; n--) begin
      if (pend[n]) begin
        cand_ok = 1'b1;
        cand_id = IDW'(n);
      end
    end
  end

  assign present = cand_ok & dist_en & cpu_en & (pmask != 16'h0) & ~act_v;
  assign cpu_irq = present;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dist_en <= 1'b0;
      cpu_en  <= 1'b0;
      pmask   <= 16'h0;
      act_v   <= 1'b0;
      act_id  <= '0;
    end else begin
      if (wr_go && dctl_hit)  dist_en <= bus_wdata[0];
      if (wr_go && cctl_hit)  cpu_en  <= bus_wdata[0];
      if (wr_go && pmask_hit) pmask   <= bus_wdata[15:0];
      if (rd_go && ack_hit && present) begin
        act_v  <= 1'b1;
        act_id <= cand_id;
      end else if (wr_go && eoi_hit && act_v && bus_wdata[IDW-1:0] == act_id) begin
        act_v <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (dctl_hit) bus_rdata[0] = dist_en;
    if (cctl_hit) bus_rdata[0] = cpu_en;
    if (pmask_hit) bus_rdata[15:0] = pmask;
    if (ack_hit) bus_rdata[IDW-1:0] = present ? cand_id : SPURIOUS;
    if (sen_hit)
      for (int n = 0; n < NSRC; n++)
        if (n / 32 == int'(bus_addr[6:2])) bus_rdata[n % 32] = en[n];
    if (tgt_hit)
      for (int n = 0; n < NSRC; n++)
        if (n / 4 == int'(bus_addr[10:2])) bus_rdata[8*(n % 4) +: 8] = tgt[n];
  end

  AST_ACK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && ack_hit && cpu_irq) |=> !cpu_irq); // R8
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v && !(wr_go && eoi_hit)) |=> (act_v && !cpu_irq)); // R8
  AST_SPURIOUS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && ack_hit && !cpu_irq) |-> bus_rdata == 32'd1023); // R7
  AST_ACK_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && ack_hit && cpu_irq) |-> bus_rdata < 32'(NSRC)); // R6
  AST_IRQ_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (|src_irq)); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!dist_en || !cpu_en || pmask == 16'h0) |-> !cpu_irq); // R4
endmodule

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
  localparam int NSRC = 64;
  localparam int NV = 8;
  localparam logic [63:0] VSRC [NV] = '{
    64'h0, 64'h20, 64'h100_0000_0000, 64'h88,
    64'h220, 64'h8000_0000_0000_0000, 64'h300_0000_0000, 64'h1_0000_0000};
  localparam int VEXP [NV] = '{1023, 1023, 1023, 3, 9, 63, 41, 32};

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src_irq = '0;
  logic bus_sel = 0, bus_wr = 0;
  logic [12:2] bus_addr = '0;
  logic [3:0] bus_be = 4'hF;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cpu_irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] d;

  always #2 clk = ~clk;

  irq_distributor #(.NSRC(NSRC)) dut (.clk, .rst_n, .src_irq, .bus_sel, .bus_wr,
    .bus_addr, .bus_be, .bus_wdata, .bus_rdata, .cpu_irq);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] v, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a[12:2]; bus_wdata = v; bus_be = be;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a[12:2];
    #1 v = bus_rdata;
    @(posedge clk); #1 bus_sel = 0;
  endtask

  task automatic irq_is(string req, logic exp);
    @(negedge clk); #1 check(req, 32'(cpu_irq), 32'(exp));
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    src_irq = '1;
    irq_is("R1 irq", 0);
    rd(13'h100, d); check("R1 enable word", d, 0);
    rd(13'h800, d); check("R1 target word", d, 0);
    rd(13'h100C, d); check("R1 ack", d, 1023);
    src_irq = '0;

    // configuration
    wr(13'h000, 1); wr(13'h1000, 1); wr(13'h1004, 32'hFFFF);
    wr(13'h100, 32'hFFFF_FFDF); wr(13'h104, 32'hFFFF_FFFF);
    for (int k = 0; k < 16; k++) wr(13'h800 + 13'(4*k), 32'h0101_0101);
    wr(13'h828, 32'h0000_0002, 4'b0001);
    wr(13'h100, 32'h0);
    rd(13'h100, d); check("R2 write-0 keeps enables", d, 32'hFFFF_FFDF);
    rd(13'h104, d); check("R2 upper word", d, 32'hFFFF_FFFF);
    rd(13'h828, d); check("R3 single byte lane", d, 32'h0101_0102);

    // vector table: R2 R3 R6 R8 R9
    for (int i = 0; i < NV; i++) begin
      src_irq = VSRC[i];
      irq_is("R6 irq level", VEXP[i] != 1023);
      rd(13'h100C, d); check("R6 ack id", d, 32'(VEXP[i]));
      if (VEXP[i] != 1023) begin
        irq_is("R8 irq held low", 0);
        rd(13'h100C, d); check("R8 second ack", d, 1023);
        wr(13'h1010, 32'(VEXP[i]));
        irq_is("R9 irq after eoi", 1);
        rd(13'h100C, d); check("R9 re-ack", d, 32'(VEXP[i]));
        wr(13'h1010, 32'(VEXP[i]));
      end
      src_irq = '0;
    end

    // R4 gating
    src_irq = 64'h8;
    wr(13'h000, 0); irq_is("R4 dist off", 0);
    wr(13'h000, 1); irq_is("R4 dist on", 1);
    wr(13'h1000, 0); irq_is("R4 cpu off", 0);
    rd(13'h100C, d); check("R7 spurious no state", d, 1023);
    wr(13'h1000, 1); irq_is("R7 irq unaffected", 1);
    // R5 priority mask
    wr(13'h1004, 0); irq_is("R5 mask zero", 0);
    wr(13'h1004, 32'hFFFF); irq_is("R5 mask open", 1);
    // R9 mismatched eoi
    rd(13'h100C, d); check("R9 ack", d, 3);
    wr(13'h1010, 4); irq_is("R9 wrong eoi ignored", 0);
    wr(13'h1010, 3); irq_is("R9 matching eoi", 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule